// File: doc/BRIEF.md
# Nibble-Parallel Transmit Payload Interface

This block takes outbound payload from terminal equipment four bits at a time and turns it into a serial bit stream for a downstream frame builder. All timing comes from the local transmit line clock. The block produces a nibble clock for the equipment by dividing the line clock by four. It captures the 4-bit input on each rising edge of that nibble clock. Each captured nibble then leaves on the serial output one bit per line clock, most significant bit first.

The equipment marks the start of each frame with a pulse on a frame-reference input. A frame is 4760 line-clock periods long. It is made of 56 blocks of 85 bits, and the first bit of each block is reserved for overhead that is inserted further down the chain. In that overhead slot the block issues no nibble-clock edge and drops its payload-valid qualifier, so each frame carries exactly 1176 nibbles (4704 payload bits). A start-of-frame marker flags the first payload bit of every frame.

A frame-reference rising edge that does not land on the expected frame boundary forces the counters back to the frame start. It also raises a one-clock misalignment flag.

Top module: `txnib_payload_if`

## Requirements
- R1: While `rst_ni` is low, and after release until the first rising edge of `frame_ref_i`, the outputs `nib_clk_o`, `ser_valid_o`, `sof_o` and `misalign_o` are all low.
- R2: Once running, `nib_clk_o` is high for two line clocks and low for two line clocks within each nibble slot. It stays low in the overhead slot of every 85-bit block, giving exactly 1176 rising edges per 4760-clock frame.
- R3: `nib_i` is captured on the line-clock edge where `nib_clk_o` rises. Its bit 3 appears on `ser_data_o` in the following cycle, then bits 2, 1 and 0 in the next three cycles.
- R4: `ser_valid_o` is low in exactly one cycle of every 85 (the first cycle of a block) and high in all other running cycles: 56 low cycles per frame.
- R5: After the clock edge that samples a rising edge on `frame_ref_i`, the next cycle is the overhead slot of block 0. The nibble captured at the following `nib_clk_o` rise is the first of the frame. `sof_o` is high with its first bit, exactly once per frame, and only while `ser_valid_o` is high.
- R6: A `frame_ref_i` rising edge sampled on the edge that ends the last cycle of a frame leaves the bit sequence undisturbed and does not raise `misalign_o`.
- R7: A `frame_ref_i` rising edge sampled at any other point of a running frame restarts the frame sequence. `misalign_o` is then high for exactly one cycle, the cycle after the sampling edge. The first edge after reset raises no flag.
- R8: Holding `frame_ref_i` high for many cycles starts only one frame; only a rising edge acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ref_i | input | 1 | Frame reference from terminal equipment; rising edge starts a frame |
| nib_i | input | 4 | Payload nibble, bit 3 sent first |
| nib_clk_o | output | 1 | Gated nibble clock toward terminal equipment |
| ser_data_o | output | 1 | Serial payload bit |
| ser_valid_o | output | 1 | High when `ser_data_o` carries payload |
| sof_o | output | 1 | High with the first payload bit of a frame |
| misalign_o | output | 1 | One-cycle pulse on a misaligned frame reference |

## Verification
A captured nibble's first bit is due in the cycle right after the `nib_clk_o` rise that captured it, and the rest follow on the next three clocks. A frame-reference edge gives the overhead slot and the misalignment flag one cycle after the sampling edge, and the start-of-frame marker one cycle after that. The bench drives inputs on falling edges and samples outputs 5 ns after each rising edge. A driver pushes the four expected bits of every nibble it presents into a queue, and a monitor pops one entry on each valid cycle, so ordering is checked independent of gap placement. Edge counts, gap counts and flag counts are taken over windows of exactly 4760 clocks that start at each frame-reference sampling edge.

// File: rtl/txnib_pkg.sv
package txnib_pkg;
  localparam int unsigned NIB_W_DEF    = 4;
  localparam int unsigned BLK_BITS_DEF = 85;   // one overhead bit + payload
  localparam int unsigned N_BLKS_DEF   = 56;
endpackage

// File: rtl/txnib_frame_timer.sv
module txnib_frame_timer #(
  parameter int unsigned BLK_BITS = 85,
  parameter int unsigned N_BLKS   = 56,
  localparam int unsigned BIT_W   = $clog2(BLK_BITS),
  localparam int unsigned BLK_W   = $clog2(N_BLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ref_i,
  output logic             run_q_o,
  output logic             run_d_o,
  output logic [BIT_W-1:0] bit_q_o,
  output logic [BIT_W-1:0] bit_d_o,
  output logic [BLK_W-1:0] blk_q_o,
  output logic             ref_rise_o,
  output logic             misalign_o
);
  logic             ref_q, run_q, run_d, misalign_q;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             ref_rise, last_bit, last_blk, at_end;

  assign ref_rise = frame_ref_i & ~ref_q;
  assign last_bit = (bit_q == BIT_W'(BLK_BITS - 1));
  assign last_blk = (blk_q == BLK_W'(N_BLKS - 1));
  assign at_end   = run_q & last_bit & last_blk;

  always_comb begin
    run_d = run_q;
    bit_d = bit_q;
    blk_d = blk_q;
    if (ref_rise) begin
      run_d = 1'b1;
      bit_d = '0;
      blk_d = '0;
    end else if (run_q) begin
      if (last_bit) begin
        bit_d = '0;
        blk_d = last_blk ? '0 : blk_q + BLK_W'(1);
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q      <= 1'b0;
      run_q      <= 1'b0;
      bit_q      <= '0;
      blk_q      <= '0;
      misalign_q <= 1'b0;
    end else begin
      ref_q      <= frame_ref_i;
      run_q      <= run_d;
      bit_q      <= bit_d;
      blk_q      <= blk_d;
      misalign_q <= ref_rise & run_q & ~at_end;
    end
  end

  assign run_q_o    = run_q;
  assign run_d_o    = run_d;
  assign bit_q_o    = bit_q;
  assign bit_d_o    = bit_d;
  assign blk_q_o    = blk_q;
  assign ref_rise_o = ref_rise;
  assign misalign_o = misalign_q;

  p_resync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_rise |=> (run_q && bit_q == '0 && blk_q == '0));
  p_flag_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_q |=> !misalign_q);
  p_aligned_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_rise && at_end) |=> !misalign_q);
  p_blk_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && last_bit && !ref_rise) |=> (bit_q == '0));
endmodule

// File: rtl/txnib_clk_gen.sv
module txnib_clk_gen #(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned BLK_BITS = 85,
  localparam int unsigned BIT_W   = $clog2(BLK_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_q_i,
  input  logic             run_d_i,
  input  logic [BIT_W-1:0] bit_q_i,
  input  logic [BIT_W-1:0] bit_d_i,
  output logic             nib_clk_o
);
  logic [BIT_W-1:0] pay_d, pay_q;
  logic             nib_d, nib_q;

  // payload index of the next cycle; high half of each nibble slot is low
  assign pay_d = bit_d_i - BIT_W'(1);
  assign pay_q = bit_q_i - BIT_W'(1);
  assign nib_d = run_d_i && (bit_d_i != '0) &&
                 ((pay_d % BIT_W'(NIB_W)) < BIT_W'(NIB_W / 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nib_q <= 1'b0;
    else         nib_q <= nib_d;
  end

  assign nib_clk_o = nib_q;

  p_rise_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nib_q) |-> (run_q_i && bit_q_i != '0 && (pay_q % BIT_W'(NIB_W)) == '0));
  p_oh_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q_i && bit_q_i == '0) |-> !nib_q);
endmodule

// File: rtl/txnib_shifter.sv
module txnib_shifter #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             ser_o
);
  logic [NIB_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= nib_i;
    else             sr_q <= {sr_q[NIB_W-2:0], 1'b0};
  end

  assign ser_o = sr_q[NIB_W-1];

  p_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ser_o == $past(nib_i[NIB_W-1])));
  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (ser_o == $past(sr_q[NIB_W-2])));
endmodule

// File: rtl/txnib_payload_if.sv
module txnib_payload_if
  import txnib_pkg::*;
#(
  parameter int unsigned NIB_W    = NIB_W_DEF,
  parameter int unsigned BLK_BITS = BLK_BITS_DEF,
  parameter int unsigned N_BLKS   = N_BLKS_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ref_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             nib_clk_o,
  output logic             ser_data_o,
  output logic             ser_valid_o,
  output logic             sof_o,
  output logic             misalign_o
);
  localparam int unsigned BIT_W = $clog2(BLK_BITS);
  localparam int unsigned BLK_W = $clog2(N_BLKS);

  logic             run_q, run_d, ref_rise, cap;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [BLK_W-1:0] blk_q;

  txnib_frame_timer #(.BLK_BITS(BLK_BITS), .N_BLKS(N_BLKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ref_i(frame_ref_i),
    .run_q_o    (run_q),
    .run_d_o    (run_d),
    .bit_q_o    (bit_q),
    .bit_d_o    (bit_d),
    .blk_q_o    (blk_q),
    .ref_rise_o (ref_rise),
    .misalign_o (misalign_o)
  );

  txnib_clk_gen #(.NIB_W(NIB_W), .BLK_BITS(BLK_BITS)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_q_i  (run_q),
    .run_d_i  (run_d),
    .bit_q_i  (bit_q),
    .bit_d_i  (bit_d),
    .nib_clk_o(nib_clk_o)
  );

  // capture at the end of the slot preceding each nibble's four payload bits
  assign cap = run_q && !ref_rise && (bit_q < BIT_W'(BLK_BITS - 1)) &&
               ((bit_q % BIT_W'(NIB_W)) == '0);

  txnib_shifter #(.NIB_W(NIB_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cap),
    .nib_i (nib_i),
    .ser_o (ser_data_o)
  );

  assign ser_valid_o = run_q && (bit_q != '0);
  assign sof_o       = run_q && (bit_q == BIT_W'(1)) && (blk_q == '0);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!nib_clk_o && !ser_valid_o && !sof_o));
  p_sof_in_payload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> ser_valid_o);
  p_cap_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> $rose(nib_clk_o));
  p_no_flag_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && ref_rise) |=> !misalign_o);
endmodule

// File: tb/txnib_payload_if_tb_top.sv
`timescale 1ns/1ps
module txnib_payload_if_tb_top;
  localparam int FRAME_CLKS = 4760;
  localparam int NIBS       = 1176;
  localparam int GAPS       = 56;

  typedef struct {
    logic b;
    logic sof;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_ref = 1'b0;
  logic [3:0] nib = 4'h0;
  logic       nib_clk_o, ser_data_o, ser_valid_o, sof_o, misalign_o;

  always #10 clk = ~clk;

  txnib_payload_if dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .frame_ref_i(frame_ref),
    .nib_i      (nib),
    .nib_clk_o  (nib_clk_o),
    .ser_data_o (ser_data_o),
    .ser_valid_o(ser_valid_o),
    .sof_o      (sof_o),
    .misalign_o (misalign_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // driver: presents one nibble after each nib clock rise, queues its bits
  logic       drv_en = 1'b0;
  logic       nib_last_drv = 1'b0;
  int         drv_idx = 0;
  int         drv_seq = 0;
  int         pat_mode = 0;
  logic [7:0] lfsr = 8'h5B;

  task automatic present_nib();
    logic [3:0] v;
    case (pat_mode)
      0: v = drv_seq[3:0];
      1: v = drv_seq[0] ? 4'hA : 4'h5;
      default: begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        v = lfsr[3:0] ^ lfsr[7:4];
      end
    endcase
    nib = v;
    for (int i = 0; i < 4; i++) q.push_back('{b: v[3-i], sof: (drv_idx == 0 && i == 0)});
    drv_idx = (drv_idx + 1) % NIBS;
    drv_seq++;
  endtask

  always @(negedge clk) begin
    if (drv_en) begin
      if (nib_clk_o && !nib_last_drv) present_nib();
      nib_last_drv = nib_clk_o;
    end
  end

  // monitor: one queue entry per valid cycle (R3, R5)
  logic mon_en = 1'b0;
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (mon_en) begin
      if (ser_valid_o) begin
        if (q.size() == 0) chk(1'b0, "R3 bit with empty queue", int'(ser_data_o), -1);
        else begin
          e = q.pop_front();
          chk(ser_data_o === e.b, "R3 serial bit order", int'(ser_data_o), int'(e.b));
          chk(sof_o === e.sof, "R5 sof marker", int'(sof_o), int'(e.sof));
        end
      end else begin
        chk(sof_o === 1'b0, "R5 sof outside payload", int'(sof_o), 0);
      end
    end
  end

  // window statistics
  int   n_rise = 0, n_gap = 0, n_sof = 0, n_mis = 0;
  logic st_last = 1'b0;
  always @(posedge clk) begin
    #5;
    if (nib_clk_o && !st_last) n_rise++;
    st_last = nib_clk_o;
    if (!ser_valid_o) n_gap++;
    if (sof_o) n_sof++;
    if (misalign_o) n_mis++;
  end

  // called at a falling edge; raises the reference and covers one frame
  task automatic run_frame(input int hold, input int mis_exp, input string lbl);
    int r0, g0, s0, m0;
    r0 = n_rise; g0 = n_gap; s0 = n_sof; m0 = n_mis;
    frame_ref = 1'b1;
    @(posedge clk); #5;
    chk(misalign_o === 1'(mis_exp), {lbl, " R7 flag after sampling edge"}, int'(misalign_o), mis_exp);
    chk(ser_valid_o === 1'b0, "R5 overhead slot after edge", int'(ser_valid_o), 0);
    chk(nib_clk_o === 1'b0, "R2 nib clock low in overhead", int'(nib_clk_o), 0);
    @(negedge clk);
    @(posedge clk); #5;
    chk(misalign_o === 1'b0, "R7 flag lasts one cycle", int'(misalign_o), 0);
    chk(sof_o === 1'b1 && ser_valid_o === 1'b1, "R5 sof one cycle after overhead", int'(sof_o), 1);
    @(negedge clk);
    repeat (hold - 2) @(negedge clk);
    frame_ref = 1'b0;
    repeat (FRAME_CLKS - hold) @(negedge clk);
    chk(n_rise - r0 == NIBS, "R2 nib clock rises per frame", n_rise - r0, NIBS);
    chk(n_gap - g0 == GAPS, "R4 overhead gaps per frame", n_gap - g0, GAPS);
    chk(n_sof - s0 == 1, "R5 sof per frame", n_sof - s0, 1);
    chk(n_mis - m0 == mis_exp, {lbl, " misalign count"}, n_mis - m0, mis_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic prevv;
    // R1: reset state
    repeat (3) @(posedge clk);
    #5;
    chk(nib_clk_o === 1'b0, "R1 nib clock in reset", int'(nib_clk_o), 0);
    chk(ser_valid_o === 1'b0 && sof_o === 1'b0, "R1 valid and sof in reset", int'(ser_valid_o), 0);
    chk(misalign_o === 1'b0, "R1 flag in reset", int'(misalign_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (50) begin
      @(posedge clk); #5;
      chk(nib_clk_o === 1'b0 && ser_valid_o === 1'b0, "R1 idle before reference", int'(nib_clk_o), 0);
    end

    // R8: first frame, reference held high 20 clocks
    @(negedge clk);
    pat_mode = 0;
    drv_idx = 0;
    present_nib();
    nib_last_drv = 1'b0;
    drv_en = 1'b1;
    mon_en = 1'b1;
    run_frame(20, 0, "R8 held-high reference");

    // R6: aligned references, different patterns
    pat_mode = 1;
    run_frame(4, 0, "R6 aligned reference");
    pat_mode = 2;
    run_frame(4, 0, "R6 aligned reference");

    // R7: misaligned reference two clocks into a nibble slot
    repeat (1000) @(negedge clk);
    @(posedge clk); #5;
    prevv = nib_clk_o;
    do begin
      @(posedge clk); #5;
      if (nib_clk_o && !prevv) break;
      prevv = nib_clk_o;
    end while (1'b1);
    @(negedge clk);
    @(negedge clk);
    // old nibble loses its last two bits; the nibble on the pins becomes the first
    if (q.size() > 2) begin
      void'(q.pop_front());
      void'(q.pop_front());
      q[0].sof = 1'b1;
    end
    drv_idx = 1;
    pat_mode = 0;
    run_frame(4, 1, "R7 misaligned reference");
    run_frame(4, 0, "R6 aligned after resync");

    // R1: asynchronous reset mid-run, then idle
    @(negedge clk);
    drv_en = 1'b0;
    mon_en = 1'b0;
    rst_ni = 1'b0;
    q.delete();
    @(posedge clk); #5;
    chk(nib_clk_o === 1'b0 && ser_valid_o === 1'b0, "R1 reset mid-run", int'(nib_clk_o), 0);
    chk(sof_o === 1'b0 && misalign_o === 1'b0, "R1 reset mid-run flags", int'(sof_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (40) begin
      @(posedge clk); #5;
      chk(nib_clk_o === 1'b0 && ser_valid_o === 1'b0, "R1 idle after reset", int'(nib_clk_o), 0);
    end
    finish_run();
  end
endmodule